// File: doc/BRIEF.md
# Shared Host/Serial Control-Status Register

This block holds one 8-bit control and status byte that two agents share. A host processor reads it at any time. It can write the whole byte at one address, or write a single bit through a bit address. A serial link engine sits on the other side and handles framed traffic. That engine changes only the bits it is allowed to change, and it does so by pulsing per-bit set and clear strobes.

From the stored bits the block drives several controls. These are an enable for writes into the receive buffer, the two link mode indications, the kind of reply sent in automatic mode (ready or not-ready), an enable for automatic replies to optional polls, and an interrupt request.

Each bit follows its own handshake. Some bits are raised by the host and dropped by the engine. Some are raised by the engine and dropped only by the host. One bit responds to the engine only while the link is in automatic mode. When both sides touch the same bit in the same cycle, the engine's event is kept, so no frame or transmit event is lost.

Top module: `link_csr_shared`

## Requirements
- R1: After reset the stored byte is 0x00. The receive write enable is high, and the interrupt request, both mode indications and both reply outputs are low.
- R2: A byte write at address REG_ADDR (default 0xC8) loads all eight bits, and `host_rdata` always shows the stored byte. Byte writes at any other address are ignored. The bit positions are: 7 transmit-full, 6 receive-empty, 5 send request, 4 interrupt, 3 overrun, 2 optional-poll, 1 mode select, 0 receive guard.
- R3: A bit write at an address whose upper five bits match REG_ADDR changes only the bit indexed by address bits 2:0, giving it the value `host_bit_val`. Bit writes outside that 8-address window are ignored. If a byte write and a bit write arrive in the same cycle, the byte write is used.
- R4: The engine's set strobes act only on bits 2, 3, 4 and 5. Its clear strobes act only on bits 1, 2, 3, 5, 6 and 7. Strobes at any other position have no effect, so the engine can never set bits 0, 1, 6 or 7 and can never clear bits 0 or 4.
- R5: If the engine pulses both set and clear for the same bit in one cycle, the bit becomes 1.
- R6: If a host write and an engine strobe hit the same bit in one cycle, the engine's value is stored. Host changes to the other bits in that cycle still take effect.
- R7: The engine's strobes on bit 5 act only while automatic mode is active. Automatic mode means bit 1 = 1 and `link_mode_sel` = 0.
- R8: `rxbuf_wr_en` is the inverse of bit 0.
- R9: When bit 1 = 1, `auto_mode` is high if `link_mode_sel` = 0 and `addressed_mode` is high if `link_mode_sel` = 1. Both are low when bit 1 = 0.
- R10: In automatic mode exactly one reply output is high: `reply_not_ready` when bit 0 = 1, otherwise `reply_ready`. Outside automatic mode both reply outputs are low.
- R11: `opt_poll_reply_en` follows bit 2 and `irq_req` follows bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Host address for byte and bit access |
| host_byte_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host byte write data |
| host_bit_wr | input | 1 | Host single-bit write strobe |
| host_bit_val | input | 1 | Value for a single-bit write |
| host_rdata | output | 8 | Current stored byte |
| link_mode_sel | input | 1 | Chooses the meaning of bit 1: 0 automatic, 1 addressed |
| eng_set | input | 8 | Engine per-bit set strobes |
| eng_clr | input | 8 | Engine per-bit clear strobes |
| rxbuf_wr_en | output | 1 | Receive buffer write enable |
| auto_mode | output | 1 | Automatic mode active |
| addressed_mode | output | 1 | Addressed mode active |
| reply_ready | output | 1 | Automatic reply is ready-to-receive |
| reply_not_ready | output | 1 | Automatic reply is not-ready |
| opt_poll_reply_en | output | 1 | Auto-reply to optional polls enabled |
| irq_req | output | 1 | Interrupt request |

## Verification
The host write path and the engine strobe path can act on the same bit in the same clock, so that collision is the central concern. The bench drives a host byte write or bit write in the very cycle the engine pulses a set or clear on an overlapping bit. It then reads back the full byte. The contested bit must carry the engine's value, and every uncontested bit must carry the host's value. A second collision is checked the same way: the engine's own set and clear strobes on one bit in one cycle, where the set must win.

// File: rtl/link_csr_pkg.sv
package link_csr_pkg;
   localparam int unsigned CSR_W = 8;

   // bit positions (the host byte layout depends on these)
   localparam int unsigned B_GUARD   = 0;
   localparam int unsigned B_MODE    = 1;
   localparam int unsigned B_OPTPOLL = 2;
   localparam int unsigned B_OVRUN   = 3;
   localparam int unsigned B_IRQ     = 4;
   localparam int unsigned B_SENDREQ = 5;
   localparam int unsigned B_RXEMPTY = 6;
   localparam int unsigned B_TXFULL  = 7;

   // which bits the serial engine may drive, per direction
   localparam logic [CSR_W-1:0] ENG_SET_OWN = 8'b0011_1100;
   localparam logic [CSR_W-1:0] ENG_CLR_OWN = 8'b1110_1110;
endpackage

// File: rtl/link_csr_host_dec.sv
module link_csr_host_dec
   import link_csr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC8
) (
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_byte_wr,
   input  logic [CSR_W-1:0]  host_wdata,
   input  logic              host_bit_wr,
   input  logic              host_bit_val,
   output logic [CSR_W-1:0]  host_we,
   output logic [CSR_W-1:0]  host_wd
);
   localparam int unsigned IDX_W = $clog2(CSR_W);

   if (ADDR_W <= IDX_W) begin : g_bad_addr_w
      $error("ADDR_W must exceed the bit index width");
   end
   if (REG_ADDR[IDX_W-1:0] != '0) begin : g_bad_align
      $error("REG_ADDR must be aligned to the register width");
   end

   logic byte_hit, bit_hit;
   logic [IDX_W-1:0] idx;

   assign idx      = host_addr[IDX_W-1:0];
   assign byte_hit = host_byte_wr && (host_addr == REG_ADDR);
   assign bit_hit  = host_bit_wr && !byte_hit &&
                     (host_addr[ADDR_W-1:IDX_W] == REG_ADDR[ADDR_W-1:IDX_W]);

   always_comb begin
      host_we = '0;
      host_wd = {CSR_W{host_bit_val}};
      if (byte_hit) begin
         host_we = '1;
         host_wd = host_wdata;
      end else if (bit_hit) begin
         host_we[idx] = 1'b1;
      end
   end

   // R3: a bit write never enables more than one bit
   always_comb begin
      if (!byte_hit) a_r3_single_bit: assert ($onehot0(host_we));
   end
endmodule

// File: rtl/link_csr_cell.sv
module link_csr_cell #(
   parameter bit CAN_SET = 1'b0,
   parameter bit CAN_CLR = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_we,
   input  logic host_d,
   input  logic eng_set,
   input  logic eng_clr,
   output logic q
);
   logic set_eff, clr_eff, nxt;

   if (CAN_SET) begin : g_set
      assign set_eff = eng_set;
   end else begin : g_noset
      assign set_eff = 1'b0;
   end
   if (CAN_CLR) begin : g_clr
      assign clr_eff = eng_clr;
   end else begin : g_noclr
      assign clr_eff = 1'b0;
   end

   always_comb begin
      nxt = q;
      if (set_eff)      nxt = 1'b1;
      else if (clr_eff) nxt = 1'b0;
      else if (host_we) nxt = host_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end

   // R5: a set strobe lands even when a clear arrives with it
   a_r5_set_beats_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (set_eff && clr_eff) |=> q);
   // R6: an engine clear beats a host write of one
   a_r6_engine_first: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_eff && !set_eff && host_we && host_d) |=> !q);
   // R4: with no permitted strobe and no host write the bit holds
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_eff && !clr_eff && !host_we) |=> q == $past(q));
endmodule

// File: rtl/link_csr_derive.sv
module link_csr_derive
   import link_csr_pkg::*;
(
   input  logic [CSR_W-1:0] q,
   input  logic             link_mode_sel,
   output logic             rxbuf_wr_en,
   output logic             auto_mode,
   output logic             addressed_mode,
   output logic             reply_ready,
   output logic             reply_not_ready,
   output logic             opt_poll_reply_en,
   output logic             irq_req
);
   assign rxbuf_wr_en       = !q[B_GUARD];
   assign auto_mode         = q[B_MODE] && !link_mode_sel;
   assign addressed_mode    = q[B_MODE] &&  link_mode_sel;
   assign reply_not_ready   = auto_mode &&  q[B_GUARD];
   assign reply_ready       = auto_mode && !q[B_GUARD];
   assign opt_poll_reply_en = q[B_OPTPOLL];
   assign irq_req           = q[B_IRQ];

   // R10: never both reply kinds; R9: never both modes
   always_comb begin
      a_r10_reply_excl: assert (!(reply_ready && reply_not_ready));
      a_r9_mode_excl:   assert (!(auto_mode && addressed_mode));
   end
endmodule

// File: rtl/link_csr_shared.sv
module link_csr_shared
   import link_csr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_byte_wr,
   input  logic [7:0]        host_wdata,
   input  logic              host_bit_wr,
   input  logic              host_bit_val,
   output logic [7:0]        host_rdata,
   input  logic              link_mode_sel,
   input  logic [7:0]        eng_set,
   input  logic [7:0]        eng_clr,
   output logic              rxbuf_wr_en,
   output logic              auto_mode,
   output logic              addressed_mode,
   output logic              reply_ready,
   output logic              reply_not_ready,
   output logic              opt_poll_reply_en,
   output logic              irq_req
);
   logic [CSR_W-1:0] q, host_we, host_wd, set_g, clr_g;
   logic             auto_int;

   link_csr_host_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
      .host_addr    (host_addr),
      .host_byte_wr (host_byte_wr),
      .host_wdata   (host_wdata),
      .host_bit_wr  (host_bit_wr),
      .host_bit_val (host_bit_val),
      .host_we      (host_we),
      .host_wd      (host_wd)
   );

   assign auto_int = q[B_MODE] && !link_mode_sel;

   // send-request responds to the engine only in automatic mode
   always_comb begin
      set_g = eng_set;
      clr_g = eng_clr;
      if (!auto_int) begin
         set_g[B_SENDREQ] = 1'b0;
         clr_g[B_SENDREQ] = 1'b0;
      end
   end

   for (genvar i = 0; i < CSR_W; i++) begin : g_bit
      link_csr_cell #(.CAN_SET(ENG_SET_OWN[i]), .CAN_CLR(ENG_CLR_OWN[i])) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .host_we (host_we[i]),
         .host_d  (host_wd[i]),
         .eng_set (set_g[i]),
         .eng_clr (clr_g[i]),
         .q       (q[i])
      );
   end

   assign host_rdata = q;

   link_csr_derive u_drv (
      .q                 (q),
      .link_mode_sel     (link_mode_sel),
      .rxbuf_wr_en       (rxbuf_wr_en),
      .auto_mode         (auto_mode),
      .addressed_mode    (addressed_mode),
      .reply_ready       (reply_ready),
      .reply_not_ready   (reply_not_ready),
      .opt_poll_reply_en (opt_poll_reply_en),
      .irq_req           (irq_req)
   );

   // R7: outside automatic mode the engine cannot move send-request
   a_r7_sendreq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_mode && !host_we[B_SENDREQ]) |=> host_rdata[B_SENDREQ] == $past(host_rdata[B_SENDREQ]));
   // R4: the interrupt bit is only dropped by the host
   a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !host_we[B_IRQ]) |=> irq_req);
   // R4: the engine never raises the transmit-full bit
   a_r4_txfull_host_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rdata[B_TXFULL] && !host_we[B_TXFULL]) |=> !host_rdata[B_TXFULL]);
endmodule

// File: tb/link_csr_shared_test.sv
`timescale 1ns/1ps
module link_csr_shared_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] host_addr = 8'h00;
   logic       host_byte_wr = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic       host_bit_wr = 1'b0;
   logic       host_bit_val = 1'b0;
   logic [7:0] host_rdata;
   logic       link_mode_sel = 1'b0;
   logic [7:0] eng_set = 8'h00;
   logic [7:0] eng_clr = 8'h00;
   logic rxbuf_wr_en, auto_mode, addressed_mode, reply_ready, reply_not_ready;
   logic opt_poll_reply_en, irq_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   link_csr_shared uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_byte_wr(host_byte_wr),
      .host_wdata(host_wdata), .host_bit_wr(host_bit_wr), .host_bit_val(host_bit_val),
      .host_rdata(host_rdata), .link_mode_sel(link_mode_sel), .eng_set(eng_set),
      .eng_clr(eng_clr), .rxbuf_wr_en(rxbuf_wr_en), .auto_mode(auto_mode),
      .addressed_mode(addressed_mode), .reply_ready(reply_ready),
      .reply_not_ready(reply_not_ready), .opt_poll_reply_en(opt_poll_reply_en),
      .irq_req(irq_req)
   );

   task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   // one clock with the given stimulus, then idle inputs; outputs are read 1 ns after the edge
   task automatic cyc(logic bw, logic [7:0] a, logic [7:0] wd, logic btw, logic bv,
                      logic [7:0] s, logic [7:0] c);
      @(negedge clk);
      host_byte_wr = bw; host_addr = a; host_wdata = wd;
      host_bit_wr = btw; host_bit_val = bv; eng_set = s; eng_clr = c;
      @(posedge clk);
      #1;
      host_byte_wr = 1'b0; host_bit_wr = 1'b0; eng_set = 8'h00; eng_clr = 8'h00;
   endtask

   task automatic wbyte(logic [7:0] v);
      cyc(1'b1, 8'hC8, v, 1'b0, 1'b0, 8'h00, 8'h00);
   endtask

   task automatic t_reset;
      chk("R1 byte", host_rdata, 8'h00);
      chk("R1 outs", {rxbuf_wr_en, irq_req, auto_mode, addressed_mode, reply_ready,
                      reply_not_ready, opt_poll_reply_en, 1'b0}, 8'h80);
   endtask

   task automatic t_byte;
      wbyte(8'hA5);
      chk("R2 load", host_rdata, 8'hA5);
      cyc(1'b1, 8'hC9, 8'h5A, 1'b0, 1'b0, 8'h00, 8'h00);
      chk("R2 wrong addr ignored", host_rdata, 8'hA5);
      wbyte(8'h00);
   endtask

   task automatic t_bit;
      cyc(1'b0, 8'hCF, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00);
      chk("R3 bit7", host_rdata, 8'h80);
      cyc(1'b0, 8'hC8, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00);
      chk("R3 bit0", host_rdata, 8'h81);
      cyc(1'b0, 8'hC8, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00);
      chk("R3 bit0 clear", host_rdata, 8'h80);
      cyc(1'b0, 8'hD0, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00);
      chk("R3 outside window", host_rdata, 8'h80);
      cyc(1'b1, 8'hC8, 8'h10, 1'b1, 1'b1, 8'h00, 8'h00);
      chk("R3 byte over bit", host_rdata, 8'h10);
      wbyte(8'h00);
   endtask

   task automatic t_engine;
      cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 8'h00);
      chk("R4 sets owned only", host_rdata, 8'h1C);
      wbyte(8'hFF);
      cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'hFF);
      chk("R4 clears owned only", host_rdata, 8'h11);
      wbyte(8'h02);
      cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h24, 8'h24);
      chk("R5 set beats clear", host_rdata, 8'h26);
      wbyte(8'h00);
   endtask

   task automatic t_race;
      cyc(1'b1, 8'hC8, 8'hC0, 1'b0, 1'b0, 8'h10, 8'h00);
      chk("R6 engine set with host byte", host_rdata, 8'hD0);
      cyc(1'b1, 8'hC8, 8'hFF, 1'b0, 1'b0, 8'h00, 8'h80);
      chk("R6 engine clear beats host byte", host_rdata, 8'h7F);
      wbyte(8'h00);
      cyc(1'b0, 8'hCE, 8'h00, 1'b1, 1'b1, 8'h00, 8'h40);
      chk("R6 engine clear beats host bit", host_rdata, 8'h00);
   endtask

   task automatic t_sendreq;
      link_mode_sel = 1'b1;
      wbyte(8'h02);
      chk("R9 addressed", {6'd0, auto_mode, addressed_mode}, 8'h01);
      cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h20, 8'h00);
      chk("R7 gated outside auto", host_rdata, 8'h02);
      link_mode_sel = 1'b0;
      #1;
      chk("R9 auto", {6'd0, auto_mode, addressed_mode}, 8'h02);
      cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h20, 8'h00);
      chk("R7 set in auto", host_rdata, 8'h22);
      cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h20);
      chk("R7 clear in auto", host_rdata, 8'h02);
   endtask

   task automatic t_derived;
      wbyte(8'h03);
      chk("R10 not-ready", {5'd0, rxbuf_wr_en, reply_ready, reply_not_ready}, 8'h01);
      wbyte(8'h02);
      chk("R10 ready", {5'd0, rxbuf_wr_en, reply_ready, reply_not_ready}, 8'h06);
      wbyte(8'h01);
      chk("R8 guard off auto", {5'd0, rxbuf_wr_en, reply_ready, reply_not_ready}, 8'h00);
      wbyte(8'h14);
      chk("R11 poll and irq", {6'd0, opt_poll_reply_en, irq_req}, 8'h03);
      wbyte(8'h00);
      chk("R11 both low", {6'd0, opt_poll_reply_en, irq_req}, 8'h00);
   endtask

   initial begin
      #1;
      t_reset;
      #11 rst_n = 1'b1;
      t_reset;
      t_byte;
      t_bit;
      t_engine;
      t_race;
      t_sendreq;
      t_derived;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule